// File: doc/BRIEF.md
# Button Repeat and Hold-Time Tracker

This block follows the debounced button lines of a remote-keyless transmitter. It looks at them only on a prescaled sample tick, which is nominally every 6.4 ms. It reports two things. The first is how often the same button combination has been pressed again shortly after it was let go. The second is how long the current press has been held. A repeated press that falls inside the repeat window raises a one-cycle request to cut short the code word now being sent. That lets a decoder give repeated presses extra meaning.

The repeat count is a 2-bit value that saturates: 00 for a first press, 01 and 10 for the second and third, and 11 for the fourth and every later one. The hold field is also 2 bits and saturating. It steps once per hold period (0.8 s, or 125 ticks by default) while the same combination stays down. A configuration input chooses what goes into the final two status bits: the hold field, or a 2-bit CRC supplied from outside. The hold field is copied into the status register only at a code-word boundary, so the value that is sent can be up to one word older than the internal count.

A three-state machine drives the block:

- ST_IDLE: no window is open.
- ST_HELD: a combination is down.
- ST_WINDOW: the buttons have been released and the repeat window is running.

The transitions are:

- IDLE→HELD: any non-zero sample.
- HELD→WINDOW: an all-zero sample.
- HELD→HELD: a different non-zero combination restarts the press.
- WINDOW→HELD: the same combination is queued, or a different combination restarts.
- WINDOW→IDLE: the window expires.

Top module: `btn_repeat_tracker`

## Requirements
- R1: Out of ST_IDLE, a non-zero sample on a tick starts a first activation. The queue count is 00 and terminate stays low.
- R2: Inside the window, a tick that samples the same combination as before raises the queue count by one. It also raises terminate for exactly the one cycle after that tick edge.
- R3: The queue count saturates at 11. A further queued press keeps it at 11 and still pulses terminate.
- R4: The release sample opens the window. A press on any of the next WIN_TICKS ticks is queued. On the WIN_TICKS-th tick that is still released, the window expires and the queue count is cleared to 00.
- R5: A different non-zero combination, seen either inside the window or while a press is held, starts a new first activation. The queue count is 00 and there is no terminate.
- R6: The hold field is cleared to 00 on each activation, whether first, queued or restarted. It then steps by one after every HOLD_TICKS ticks on which the same combination is still sampled, and saturates at 11.
- R7: The status register takes the hold field only on a cycle with word_end high. Between boundaries it keeps its old value.
- R8: The status_bits output is the latched hold field when sel_time is 1, and crc_in when sel_time is 0.
- R9: Button changes on cycles without a tick are ignored. The queue count and terminate are unchanged.
- R10: After reset, the queue count, terminate and the latched hold field are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample strobe, one cycle wide |
| btn | input | NBTN | Debounced button lines, active high |
| word_end | input | 1 | Code-word boundary strobe; latches the hold field |
| sel_time | input | 1 | 1: status carries the hold field; 0: status carries crc_in |
| crc_in | input | 2 | Externally computed CRC bits |
| queue_cnt | output | 2 | Saturating repeat count |
| terminate | output | 1 | One-cycle request to end the current code word |
| status_bits | output | 2 | Final two status bits of the word |

## Verification
The queue count and terminate are registered, and both are due in the cycle that follows the clock edge at which tick was high. The bench therefore drives each tick for one cycle and compares these outputs at the falling edge that comes right after that rising edge. The latched hold field appears on status_bits one cycle after the word_end edge. The selection by sel_time is combinational, so the bench compares status_bits at the falling edge after the boundary strobe, or after a change of sel_time or crc_in. The bench also reads status_bits before a boundary strobe, which shows the one-word lag.

// File: rtl/btn_trk_pkg.sv
package btn_trk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HELD   = 2'd1,
        ST_WINDOW = 2'd2
    } trk_state_e;
endpackage

// File: rtl/trk_step_cnt.sv
module trk_step_cnt #(
    parameter int LIMIT = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic at_last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (en)     cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    // R4 / R6: the step count never leaves its period
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/trk_fsm.sv
module trk_fsm
    import btn_trk_pkg::*;
#(
    parameter int NBTN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NBTN-1:0] btn,
    input  logic            win_last,
    output logic [1:0]      queue_cnt,
    output logic            terminate,
    output logic            hold_clr,
    output logic            hold_en,
    output logic            win_clr,
    output logic            win_en
);
    trk_state_e      state_q, state_d;
    logic [NBTN-1:0] combo_q, combo_d;
    logic [1:0]      queue_q, queue_d;
    logic            term_q, term_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            combo_q <= '0;
            queue_q <= 2'b00;
            term_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            combo_q <= combo_d;
            queue_q <= queue_d;
            term_q  <= term_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        combo_d  = combo_q;
        queue_d  = queue_q;
        term_d   = 1'b0;
        hold_clr = 1'b0;
        hold_en  = 1'b0;
        win_clr  = 1'b0;
        win_en   = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (btn != '0) begin
                        state_d  = ST_HELD;
                        combo_d  = btn;
                        queue_d  = 2'b00;
                        hold_clr = 1'b1;
                    end
                end
                ST_HELD: begin
                    if (btn == '0) begin
                        state_d = ST_WINDOW;
                        win_clr = 1'b1;
                    end else if (btn == combo_q) begin
                        hold_en = 1'b1;
                    end else begin
                        combo_d  = btn;
                        queue_d  = 2'b00;
                        hold_clr = 1'b1;
                    end
                end
                ST_WINDOW: begin
                    if (btn == '0) begin
                        win_en = 1'b1;
                        if (win_last) begin
                            state_d = ST_IDLE;
                            queue_d = 2'b00;
                        end
                    end else if (btn == combo_q) begin
                        state_d  = ST_HELD;
                        hold_clr = 1'b1;
                        term_d   = 1'b1;
                        if (queue_q != 2'b11) queue_d = queue_q + 2'b01;
                    end else begin
                        state_d  = ST_HELD;
                        combo_d  = btn;
                        queue_d  = 2'b00;
                        hold_clr = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign queue_cnt = queue_q;
    assign terminate = term_q;

    // R2: a terminate request follows only a sampled tick
    p_term_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        terminate |-> $past(tick));
    // R2: a queued press never reports a first activation
    p_term_nonzero_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
        terminate |-> (queue_cnt != 2'b00));
    // R3: the count never wraps from 11 to 01 or 10
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_cnt == 2'b11) |=> (queue_cnt == 2'b11 || queue_cnt == 2'b00));
    // R9: without a tick the count holds
    p_q_stable_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(queue_cnt));
endmodule

// File: rtl/btn_repeat_tracker.sv
module btn_repeat_tracker #(
    parameter int NBTN       = 4,
    parameter int HOLD_TICKS = 125,
    parameter int WIN_TICKS  = 312
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NBTN-1:0] btn,
    input  logic            word_end,
    input  logic            sel_time,
    input  logic [1:0]      crc_in,
    output logic [1:0]      queue_cnt,
    output logic            terminate,
    output logic [1:0]      status_bits
);
    logic hold_clr, hold_en, win_clr, win_en;
    logic hold_last, win_last;
    logic [1:0] hold_q, hold_out_q;

    trk_fsm #(.NBTN(NBTN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .btn       (btn),
        .win_last  (win_last),
        .queue_cnt (queue_cnt),
        .terminate (terminate),
        .hold_clr  (hold_clr),
        .hold_en   (hold_en),
        .win_clr   (win_clr),
        .win_en    (win_en)
    );

    trk_step_cnt #(.LIMIT(HOLD_TICKS)) u_hold_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hold_clr),
        .en      (hold_en),
        .at_last (hold_last)
    );

    trk_step_cnt #(.LIMIT(WIN_TICKS)) u_win_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (win_clr),
        .en      (win_en),
        .at_last (win_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      hold_q <= 2'b00;
        else if (hold_clr)                               hold_q <= 2'b00;
        else if (hold_en && hold_last && hold_q != 2'b11) hold_q <= hold_q + 2'b01;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hold_out_q <= 2'b00;
        else if (word_end) hold_out_q <= hold_q;
    end

    assign status_bits = sel_time ? hold_out_q : crc_in;

    // R6: the hold field stays at 11 until a new activation
    p_hold_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q == 2'b11 && !hold_clr) |=> (hold_q == 2'b11));
    // R7: the sent value only moves at a word boundary
    p_latch_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !word_end |=> $stable(hold_out_q));
endmodule

// File: tb/btn_repeat_tracker_bench.sv
module btn_repeat_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBTN = 4;
    localparam int HOLD = 3;
    localparam int WIN  = 5;
    localparam int NVEC = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [NBTN-1:0] btn = '0;
    logic word_end = 1'b0;
    logic sel_time = 1'b1;
    logic [1:0] crc_in = 2'b00;
    logic [1:0] queue_cnt;
    logic terminate;
    logic [1:0] status_bits;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_repeat_tracker #(.NBTN(NBTN), .HOLD_TICKS(HOLD), .WIN_TICKS(WIN)) u_btn_repeat_tracker (
        .clk(clk), .rst_n(rst_n), .tick(tick), .btn(btn), .word_end(word_end),
        .sel_time(sel_time), .crc_in(crc_in), .queue_cnt(queue_cnt),
        .terminate(terminate), .status_bits(status_bits)
    );

    // {btn[3:0], expected queue[1:0], expected terminate, requirement number[3:0]}
    localparam logic [10:0] VEC [NVEC] = '{
        {4'b0001, 2'd0, 1'b0, 4'd1},   // R1 first press
        {4'b0000, 2'd0, 1'b0, 4'd4},   // release opens window
        {4'b0000, 2'd0, 1'b0, 4'd4},
        {4'b0001, 2'd1, 1'b1, 4'd2},   // R2 second
        {4'b0000, 2'd1, 1'b0, 4'd2},
        {4'b0001, 2'd2, 1'b1, 4'd2},   // third
        {4'b0000, 2'd2, 1'b0, 4'd2},
        {4'b0001, 2'd3, 1'b1, 4'd3},   // fourth
        {4'b0000, 2'd3, 1'b0, 4'd3},
        {4'b0001, 2'd3, 1'b1, 4'd3},   // R3 saturate
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0001, 2'd3, 1'b1, 4'd4},   // R4 last tick of window still queues
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd3, 1'b0, 4'd4},
        {4'b0000, 2'd0, 1'b0, 4'd4},   // R4 expiry
        {4'b0001, 2'd0, 1'b0, 4'd1},
        {4'b0000, 2'd0, 1'b0, 4'd1},
        {4'b0001, 2'd1, 1'b1, 4'd2},
        {4'b0000, 2'd1, 1'b0, 4'd2},
        {4'b0011, 2'd0, 1'b0, 4'd5},   // R5 other combo in window
        {4'b0000, 2'd0, 1'b0, 4'd5},
        {4'b0011, 2'd1, 1'b1, 4'd2},
        {4'b0110, 2'd0, 1'b0, 4'd5},   // R5 other combo while held
        {4'b0110, 2'd0, 1'b0, 4'd5},
        {4'b0000, 2'd0, 1'b0, 4'd5}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_tick(input logic [NBTN-1:0] b);
        btn  = b;
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_word_end();
        word_end = 1'b1;
        @(posedge clk);
        @(negedge clk);
        word_end = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick = 1'b0;
        word_end = 1'b0;
        btn = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        check("R10", "queue after reset", queue_cnt, 0);
        check("R10", "terminate after reset", terminate, 0);
        check("R10", "status after reset", status_bits, 0);

        for (int i = 0; i < NVEC; i++) begin
            automatic logic [10:0] v = VEC[i];
            automatic string tag = $sformatf("R%0d", v[3:0]);
            do_tick(v[10:7]);
            check(tag, $sformatf("queue vec %0d", i), queue_cnt, v[6:5]);
            check(tag, $sformatf("terminate vec %0d", i), terminate, v[4]);
        end

        // R9: press 0110 again inside the window, then wiggle buttons without tick
        do_tick(4'b0110);
        check("R2", "queue requeue", queue_cnt, 1);
        btn = 4'b1001;
        repeat (3) @(negedge clk);
        btn = 4'b0000;
        repeat (3) @(negedge clk);
        check("R9", "queue without tick", queue_cnt, 1);
        check("R9", "terminate without tick", terminate, 0);

        // hold-time field
        do_reset();
        sel_time = 1'b1;
        do_tick(4'b1000);
        do_word_end();
        check("R6", "hold at activation", status_bits, 0);
        repeat (HOLD) do_tick(4'b1000);
        check("R7", "status lags before boundary", status_bits, 0);
        do_word_end();
        check("R6", "hold after one period", status_bits, 1);
        repeat (HOLD - 1) do_tick(4'b1000);
        do_word_end();
        check("R6", "hold one tick short", status_bits, 1);
        do_tick(4'b1000);
        do_word_end();
        check("R6", "hold after two periods", status_bits, 2);
        repeat (HOLD) do_tick(4'b1000);
        do_word_end();
        check("R6", "hold after three periods", status_bits, 3);
        repeat (2 * HOLD) do_tick(4'b1000);
        do_word_end();
        check("R6", "hold saturates", status_bits, 3);

        // R8 selection
        sel_time = 1'b0;
        crc_in = 2'b10;
        @(negedge clk);
        check("R8", "crc selected", status_bits, 2);
        crc_in = 2'b01;
        @(negedge clk);
        check("R8", "crc follows input", status_bits, 1);
        sel_time = 1'b1;
        @(negedge clk);
        check("R8", "hold reselected", status_bits, 3);

        // R6 clear on queued press; R7 boundary needed to see it
        do_tick(4'b0000);
        do_tick(4'b1000);
        check("R2", "queue on repeat", queue_cnt, 1);
        check("R7", "status before boundary", status_bits, 3);
        do_word_end();
        check("R6", "hold cleared on repeat", status_bits, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule